// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block turns a single kernel clock into the timing references of a serial audio port. These are a master clock (MCK) at 256 times the sample rate, a bit clock (BCK), and a one-cycle tick that marks the end of each channel slot. The sample rate is set by a divide ratio N = 2·div + odd, so the ratio can be odd. Both clocks are produced as registered levels that run in the kernel clock domain, and they change only on kernel clock edges.

There are two post-divide arrangements. With the master clock enabled, MCK has period N, and BCK is MCK divided down to 32 or 64 bit periods per frame. With the master clock disabled, MCK is held low and BCK itself has period N. The configuration inputs are captured when the block starts. While the block runs it ignores them. Clearing the enable stops all outputs at the next edge.

Top module: `audio_clk_div`

## Requirements
- R1: The effective ratio is N = 2·div_i + odd_i, where odd_i is the least significant bit of N. With mck_en_i = 1, mck_o has period N, is low for floor(N/2) cycles and high for ceil(N/2) cycles, and rises floor(N/2) cycles after the edge that starts the block.
- R2: A div_i value of 0 or 1 is treated as 2, so N is 4 or 5 and never smaller.
- R3: With mck_en_i = 1, bck_o has period 4·N when ch32_i = 1 (64 bits per frame) and 8·N when ch32_i = 0 (32 bits per frame). Every bck_o edge falls in the same cycle as a falling edge of mck_o.
- R4: With mck_en_i = 0, mck_o stays low. bck_o has period N and the same low/high split as R1.
- R5: ws_tick_o is a single-cycle pulse. It occurs on every 32nd (ch32_i = 1) or 16th (ch32_i = 0) falling edge of bck_o, in the same cycle as that edge.
- R6: After start, bck_o first rises after floor(N/2) cycles when mck_en_i = 0. When mck_en_i = 1, it first rises after half a bit period, N·4/2 or N·8/2 cycles.
- R7: div_i, odd_i, mck_en_i and ch32_i are captured on the edge where en_i is first seen high. Changes to them while en_i stays high have no effect until the block is stopped and started again.
- R8: One edge after en_i is seen low, all three outputs are low. While rst_n is low they are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable |
| div_i | input | 8 | Integer part of the ratio (upper bits of N) |
| odd_i | input | 1 | Least significant bit of N |
| mck_en_i | input | 1 | 1: produce MCK and derive BCK from it |
| ch32_i | input | 1 | Channel length: 1 = 32 bits, 0 = 16 bits |
| mck_o | output | 1 | Master clock, low when disabled |
| bck_o | output | 1 | Bit clock |
| ws_tick_o | output | 1 | One-cycle end-of-channel pulse |

## Verification
Every output is a register, so the cycle at which each value is due can be counted from the starting edge E0, the first edge that sees en_i high. With c edges after E0, mck_o is due high when (c mod N) is at least floor(N/2). In master mode bck_o is due high when floor(c/(N·R/2)) is odd, where R is 4 or 8. ws_tick_o is due exactly when c is a non-zero multiple of the channel period, and all outputs are due low one edge after en_i drops. The bench computes these closed forms for every c and samples 2 ns after each rising edge, so each comparison falls in the cycle the value is due.

// File: rtl/acd_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, fixed audio ratios and the configuration record
// for the audio clock divider. Assumes channel lengths of 16 or 32 bits.
package acd_pkg;
    localparam int DIV_W       = 8;
    localparam int N_W         = DIV_W + 1;
    localparam int MIN_DIV     = 2;
    localparam int MCK_PER_FS  = 256;
    localparam int SLOT_SHORT  = 16;
    localparam int SLOT_LONG   = 32;
    // MCK falling edges per half bit period in each channel-length mode
    localparam int HALF_LONG   = MCK_PER_FS / (4 * SLOT_LONG);
    localparam int HALF_SHORT  = MCK_PER_FS / (4 * SLOT_SHORT);
    localparam int Q_W         = $clog2(HALF_SHORT);
    localparam int SLOT_W      = $clog2(SLOT_LONG);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             odd;
        logic             mck_en;
        logic             ch32;
    } acd_cfg_t;

    // Effective ratio with the small-divider clamp applied
    function automatic logic [N_W-1:0] eff_ratio(input acd_cfg_t c);
        logic [DIV_W-1:0] d;
        d = (c.div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : c.div;
        return {d, c.odd};
    endfunction
endpackage

// File: rtl/acd_prescale.sv
`timescale 1ns/1ps
// Module: ratio counter producing the MCK-rate phase signal.
// Period is ratio cycles, low floor(ratio/2) then high ceil(ratio/2).
// Also gives next-edge event flags so later stages stay edge aligned.
// Assumes ratio >= 4 and stable while active.
module acd_prescale
    import acd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic [N_W-1:0] ratio,
    output logic           ph_q,
    output logic           rise_nxt,
    output logic           wrap_nxt
);
    logic [N_W-1:0] cnt_q;
    logic [N_W-1:0] cnt_nxt;
    logic [N_W-1:0] low_len;

    // Next count and the events that occur on the coming edge
    always_comb begin
        low_len  = ratio >> 1;
        wrap_nxt = active && (cnt_q == ratio - N_W'(1));
        cnt_nxt  = (cnt_q == ratio - N_W'(1)) ? '0 : cnt_q + N_W'(1);
        rise_nxt = active && (cnt_nxt == low_len);
    end

    // Counter and phase register, cleared whenever the block is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ph_q  <= (cnt_nxt >= low_len);
        end
    end
endmodule

// File: rtl/acd_bitgen.sv
`timescale 1ns/1ps
// Module: bit clock generator. In direct mode it follows the prescaler
// phase. In master mode it toggles on every HALF-th MCK falling edge.
// Exposes the next-edge BCK falling event for the slot counter.
module acd_bitgen
    import acd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic mck_mode,
    input  logic ch32,
    input  logic rise_nxt,
    input  logic wrap_nxt,
    output logic bck_q,
    output logic fall_nxt
);
    logic [Q_W-1:0] q_cnt;
    logic [Q_W-1:0] half_lim;
    logic           toggle;
    logic           bck_nxt;

    // Select the toggle rule for the active mode
    always_comb begin
        half_lim = ch32 ? Q_W'(HALF_LONG - 1) : Q_W'(HALF_SHORT - 1);
        toggle   = wrap_nxt && (q_cnt == half_lim);
        if (mck_mode) begin
            bck_nxt  = toggle ? !bck_q : bck_q;
            fall_nxt = toggle && bck_q;
        end else begin
            bck_nxt  = rise_nxt ? 1'b1 : (wrap_nxt ? 1'b0 : bck_q);
            fall_nxt = wrap_nxt;
        end
    end

    // Bit clock level and MCK-fall counter
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            q_cnt <= '0;
            bck_q <= 1'b0;
        end else begin
            bck_q <= bck_nxt;
            if (wrap_nxt)
                q_cnt <= toggle ? '0 : q_cnt + Q_W'(1);
        end
    end
endmodule

// File: rtl/acd_slotcnt.sv
`timescale 1ns/1ps
// Module: counts BCK falling edges and pulses one cycle at the end of each
// channel slot of 16 or 32 bits. The pulse is registered on the same edge
// as the BCK fall it marks.
module acd_slotcnt
    import acd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ch32,
    input  logic fall_nxt,
    output logic tick_q
);
    logic [SLOT_W-1:0] bit_cnt;
    logic [SLOT_W-1:0] lim;
    logic              last;

    // Slot boundary detection
    always_comb begin
        lim  = ch32 ? SLOT_W'(SLOT_LONG - 1) : SLOT_W'(SLOT_SHORT - 1);
        last = fall_nxt && (bit_cnt == lim);
    end

    // Bit counter and tick register
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= last;
            if (fall_nxt)
                bit_cnt <= last ? '0 : bit_cnt + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/audio_clk_div.sv
`timescale 1ns/1ps
// Module: top of the audio clock divider. Captures configuration while idle,
// runs the prescaler, bit clock and slot stages while enabled.
// Assumes all inputs are synchronous to clk.
module audio_clk_div
    import acd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             mck_en_i,
    input  logic             ch32_i,
    output logic             mck_o,
    output logic             bck_o,
    output logic             ws_tick_o
);
    acd_cfg_t       cfg_q;
    logic           run_q;
    logic           active;
    logic           mck_mode_q;
    logic [N_W-1:0] ratio;
    logic           ph;
    logic           rise_nxt;
    logic           wrap_nxt;
    logic           fall_nxt;

    // Run flag and configuration capture while not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cfg_q <= '{div: DIV_W'(MIN_DIV), odd: 1'b0, mck_en: 1'b0, ch32: 1'b0};
        end else begin
            run_q <= en_i;
            if (!run_q)
                cfg_q <= '{div: div_i, odd: odd_i, mck_en: mck_en_i, ch32: ch32_i};
        end
    end

    // Derived control values
    always_comb begin
        active     = en_i && run_q;
        mck_mode_q = cfg_q.mck_en;
        ratio      = eff_ratio(cfg_q);
    end

    acd_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ratio    (ratio),
        .ph_q     (ph),
        .rise_nxt (rise_nxt),
        .wrap_nxt (wrap_nxt)
    );

    acd_bitgen u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .mck_mode (mck_mode_q),
        .ch32     (cfg_q.ch32),
        .rise_nxt (rise_nxt),
        .wrap_nxt (wrap_nxt),
        .bck_q    (bck_o),
        .fall_nxt (fall_nxt)
    );

    acd_slotcnt u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ch32     (cfg_q.ch32),
        .fall_nxt (fall_nxt),
        .tick_q   (ws_tick_o)
    );

    assign mck_o = ph && mck_mode_q;
endmodule

// File: rtl/acd_checker.sv
`timescale 1ns/1ps
// Module: temporal checks on the audio clock divider outputs, bound to the top.
module acd_checker (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic run_q,
    input logic mck_mode_q,
    input logic mck_o,
    input logic bck_o,
    input logic ws_tick_o
);
    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!mck_o && !bck_o && !ws_tick_o));

    // R4
    mck_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mck_mode_q |-> !mck_o);

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ws_tick_o |=> !ws_tick_o);

    // R5
    tick_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ws_tick_o |-> $fell(bck_o));

    // R3
    bck_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mck_mode_q && run_q && !$stable(bck_o)) |-> $fell(mck_o));
endmodule

bind audio_clk_div acd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .run_q      (run_q),
    .mck_mode_q (mck_mode_q),
    .mck_o      (mck_o),
    .bck_o      (bck_o),
    .ws_tick_o  (ws_tick_o)
);

// File: tb/sim_audio_clk_div.sv
`timescale 1ns/1ps
module sim_audio_clk_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [7:0] div_i = 8'd2;
    logic       odd_i = 1'b0;
    logic       mck_en_i = 1'b0;
    logic       ch32_i = 1'b0;
    logic       mck_o, bck_o, ws_tick_o;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    audio_clk_div u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i), .odd_i(odd_i),
        .mck_en_i(mck_en_i), .ch32_i(ch32_i),
        .mck_o(mck_o), .bck_o(bck_o), .ws_tick_o(ws_tick_o)
    );

    // Vector format: {div[7:0], odd, mck_en, ch32}
    localparam int NV = 7;
    localparam logic [10:0] VEC [NV] = '{
        {8'd2, 1'b0, 1'b0, 1'b0},
        {8'd2, 1'b1, 1'b0, 1'b1},
        {8'd3, 1'b0, 1'b1, 1'b1},
        {8'd2, 1'b1, 1'b1, 1'b0},
        {8'd7, 1'b1, 1'b0, 1'b0},
        {8'd0, 1'b1, 1'b0, 1'b0},
        {8'd1, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Closed-form expectation, c edges after the starting edge
    function automatic void model(input int c, input int n, input bit mk, input bit c32,
                                  output bit em, output bit eb, output bit et);
        int l, r, chl, p;
        l   = n / 2;
        r   = mk ? (c32 ? 4 : 8) : 1;
        chl = c32 ? 32 : 16;
        p   = n * r;
        em  = mk ? ((c % n) >= l) : 1'b0;
        eb  = mk ? (((c / (p / 2)) % 2) == 1) : ((c % n) >= l);
        et  = (c > 0) && ((c % (p * chl)) == 0);
    endfunction

    task automatic run_window(input logic [7:0] dv, input bit od, input bit mk,
                              input bit c32, input int chg_at);
        int d, n, p, len, bad_m, bad_b, bad_t, first_rise, exp_rise;
        int am, ab, at, xm, xb, xt;
        bit em, eb, et;
        string tm, tb;
        d   = (dv < 2) ? 2 : dv;
        n   = 2 * d + od;
        p   = n * (mk ? (c32 ? 4 : 8) : 1);
        len = 2 * p * (c32 ? 32 : 16) + 4;
        exp_rise = mk ? p / 2 : n / 2;
        bad_m = 0; bad_b = 0; bad_t = 0; first_rise = -1;
        am = 0; ab = 0; at = 0; xm = 0; xb = 0; xt = 0;
        tm = (chg_at >= 0) ? "R7" : ((dv < 2) ? "R2" : (mk ? "R1" : "R4"));
        tb = (chg_at >= 0) ? "R7" : (mk ? "R3" : "R4");
        @(negedge clk);
        div_i = dv; odd_i = od; mck_en_i = mk; ch32_i = c32; en_i = 1'b1;
        for (int c = 0; c <= len; c++) begin
            @(posedge clk);
            #2;
            model(c, n, mk, c32, em, eb, et);
            if (mck_o !== em && bad_m == 0) begin am = mck_o; xm = em; end
            if (bck_o !== eb && bad_b == 0) begin ab = bck_o; xb = eb; end
            if (ws_tick_o !== et && bad_t == 0) begin at = ws_tick_o; xt = et; end
            if (mck_o !== em) bad_m++;
            if (bck_o !== eb) bad_b++;
            if (ws_tick_o !== et) bad_t++;
            if (bck_o === 1'b1 && first_rise < 0) first_rise = c;
            if (c == chg_at) begin
                div_i = dv + 8'd5; mck_en_i = !mk; ch32_i = !c32; odd_i = !od;
            end
        end
        check(bad_m == 0, {tm, " mck_o waveform"}, am, xm);
        check(bad_b == 0, {tb, " bck_o waveform"}, ab, xb);
        check(bad_t == 0, "R5 ws_tick_o timing", at, xt);
        check(first_rise == exp_rise, "R6 first bck_o rise cycle", first_rise, exp_rise);
        // R8: stop clears everything one edge later
        @(negedge clk);
        en_i = 1'b0;
        @(posedge clk);
        #2;
        check({mck_o, bck_o, ws_tick_o} == 3'b000, "R8 outputs after stop",
              int'({mck_o, bck_o, ws_tick_o}), 0);
    endtask

    initial begin
        // R8: reset state, even with enable requested
        en_i = 1'b1; mck_en_i = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        check({mck_o, bck_o, ws_tick_o} == 3'b000, "R8 outputs in reset",
              int'({mck_o, bck_o, ws_tick_o}), 0);
        @(negedge clk);
        en_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++)
            run_window(VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0], -1);
        // R1: largest ratio 511
        run_window(8'd255, 1'b1, 1'b0, 1'b0, -1);
        // R7: config changes mid-run are ignored, then taken at next start
        run_window(8'd3, 1'b0, 1'b0, 1'b1, 20);
        run_window(8'd8, 1'b1, 1'b1, 1'b0, -1);
        // R8: reset while running
        @(negedge clk);
        div_i = 8'd2; odd_i = 1'b0; mck_en_i = 1'b1; ch32_i = 1'b1; en_i = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check({mck_o, bck_o, ws_tick_o} == 3'b000, "R8 outputs after mid-run reset",
              int'({mck_o, bck_o, ws_tick_o}), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule